// File: doc/BRIEF.md
# Multi-Rate Row Refresh Scheduler

This block decides, row by row, when a DRAM bank set receives refresh commands. Every base refresh period it visits all rows of all banks once, in a fixed order. For each row it looks up two Bloom filters, one for rows that need the fastest rate and one for rows that need half that rate. It then refreshes the row now or skips it for this period. Rows that appear in neither filter fall back to the slowest rate, which is one period in four. When a row hits both filters, the fast rate wins.

There is no stored state per row. A two-bit period counter (the epoch) is compared with the low bits of the row number. This spreads the slower rows evenly over the periods and gives each one an exact spacing of two or four periods. Software fills the filters through a small configuration port, which can insert a key into either filter or wipe either filter.

Every command holds the shared command bus for `CMD_CYCLES` clocks and its target bank for `BANK_CYCLES` clocks. The walk waits on a row that is due until both the bus and the bank are free, so no refresh is ever dropped.

Top module: `multirate_refresh_sched`

## Requirements
- R1: While reset is high, `ref_valid` is 0. The reset clears both filters and starts epoch 0 with row index 0. That first row, if due, is issued so that `ref_valid` is high in the first cycle after the first clock edge with reset low.
- R2: Each base period of `PERIOD_CYCLES` clocks visits every flat index once, in ascending order. The index is row*BANKS + bank, so the bank is the index modulo BANKS and the row is the index divided by BANKS. Commands within a period therefore appear with strictly increasing index.
- R3: Filter keys are flat indices. With M = `FILTER_BITS`, the two hashes are h1 = key mod M and h2 = (5*key + 3) mod M. An insert sets both bits in the selected filter. A probe hits only when both of its bits are set, so false positives from shared bits are expected.
- R4: A wipe clears only the selected filter. When a wipe and an insert arrive in the same cycle, the wipe wins.
- R5: A row that hits the fast filter is refreshed in every period, with `ref_class` = 1.
- R6: A row that hits only the medium filter is refreshed in the periods where bit 0 of the epoch equals bit 0 of its row number, with `ref_class` = 2.
- R7: A row that hits both filters follows the fast rule and is reported with `ref_class` = 1.
- R8: A row that hits neither filter is refreshed when epoch[1:0] equals row[1:0], with `ref_class` = 3. The epoch is 0 in the first period after reset and increments at each period boundary.
- R9: Two consecutive commands are at least `CMD_CYCLES` clocks apart.
- R10: Two commands to the same bank are at least `BANK_CYCLES` clocks apart.
- R11: A due row that finds the bus or its bank busy holds the walk until both are free. Every due row is still issued within its period, even when all rows are due.
- R12: A configuration write takes effect at the next clock edge (`cfg_fast_bin` = 1 selects the fast filter) and applies to every row visited after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_insert | input | 1 | Insert `cfg_key` into the selected filter |
| cfg_wipe | input | 1 | Clear the selected filter |
| cfg_fast_bin | input | 1 | 1 selects the fast filter, 0 the medium filter |
| cfg_key | input | log2(ROWS*BANKS) | Flat row index to insert |
| ref_valid | output | 1 | Refresh command issued this cycle |
| ref_bank | output | log2(BANKS) | Target bank |
| ref_row | output | log2(ROWS) | Target row |
| ref_class | output | 2 | Rate that triggered the command: 1 fast, 2 medium, 3 default |

## Verification
The bench runs a small configuration (2 banks, 8 rows, 8-bit filters) and observes 14 consecutive periods. It starts with empty filters, which shows the four-way spread of the default rate. It then adds sparse fast and medium keys, where one shared bit pair produces a false positive. Next it adds a key to both filters to show that the fast rate wins. It then applies a wipe and an insert in the same cycle and checks that the fast filter is left intact. Finally it fills the fast filter so that every row is due and the walk must stall on the bus and bank timers. In every period the bench compares each index's command count and class against its own filter model, and it measures the spacing of commands on the bus and within each bank.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

    typedef enum logic [1:0] {
        RC_NONE = 2'd0,
        RC_FAST = 2'd1,
        RC_MED  = 2'd2,
        RC_SLOW = 2'd3
    } rate_class_e;

    typedef struct packed {
        logic        due;
        rate_class_e cls;
    } verdict_t;

    // First hash: identity, truncated by the caller to the filter index width
    function automatic logic [31:0] hash_lo(input logic [31:0] key);
        return key;
    endfunction

    // Second hash: affine mix, truncated by the caller
    function automatic logic [31:0] hash_mix(input logic [31:0] key);
        return (key * 32'd5) + 32'd3;
    endfunction

    // Rate decision for one row in the current epoch
    function automatic verdict_t judge(input logic       fast_hit,
                                       input logic       med_hit,
                                       input logic [1:0] epoch,
                                       input logic [1:0] row_lsbs);
        verdict_t v;
        if (fast_hit) begin
            v.due = 1'b1;
            v.cls = RC_FAST;
        end else if (med_hit) begin
            v.due = (epoch[0] == row_lsbs[0]);
            v.cls = RC_MED;
        end else begin
            v.due = (epoch == row_lsbs);
            v.cls = RC_SLOW;
        end
        return v;
    endfunction

endpackage

// File: rtl/mrr_bloom.sv
module mrr_bloom
    import mrr_pkg::*;
#(
    parameter int KEY_W       = 18,
    parameter int FILTER_BITS = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  logic             insert,
    input  logic [KEY_W-1:0] ins_key,
    input  logic [KEY_W-1:0] probe_key,
    output logic             hit
);
    localparam int IDX_W = $clog2(FILTER_BITS);

    logic [FILTER_BITS-1:0] bits_q;
    logic [IDX_W-1:0]       ins_a, ins_b, prb_a, prb_b;

    always_comb begin
        ins_a = IDX_W'(hash_lo(32'(ins_key)));
        ins_b = IDX_W'(hash_mix(32'(ins_key)));
        prb_a = IDX_W'(hash_lo(32'(probe_key)));
        prb_b = IDX_W'(hash_mix(32'(probe_key)));
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            bits_q <= '0;
        end else if (insert) begin
            bits_q[ins_a] <= 1'b1;
            bits_q[ins_b] <= 1'b1;
        end
    end

    assign hit = bits_q[prb_a] & bits_q[prb_b];

    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (bits_q == '0)); // R4

    AST_INSERT_SETS: assert property (@(posedge clk) disable iff (rst)
        (insert && !wipe) |=> (bits_q[$past(ins_a)] && bits_q[$past(ins_b)])); // R3

endmodule

// File: rtl/mrr_occupancy.sv
module mrr_occupancy
    import mrr_pkg::*;
#(
    parameter int BANKS       = 8,
    parameter int CMD_CYCLES  = 5,
    parameter int BANK_CYCLES = 40
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     issue,
    input  logic [$clog2(BANKS)-1:0] issue_bank,
    output logic                     cmd_free,
    output logic [BANKS-1:0]         bank_free
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int CMD_W  = $clog2(CMD_CYCLES + 1);
    localparam int BNK_W  = $clog2(BANK_CYCLES + 1);

    logic [CMD_W-1:0] cmd_q;

    always_ff @(posedge clk) begin
        if (rst)
            cmd_q <= '0;
        else if (issue)
            cmd_q <= CMD_W'(CMD_CYCLES - 1);
        else if (cmd_q != '0)
            cmd_q <= cmd_q - 1'b1;
    end

    assign cmd_free = (cmd_q == '0);

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [BNK_W-1:0] busy_q;
        logic             take;

        assign take = issue && (issue_bank == BANK_W'(g));

        always_ff @(posedge clk) begin
            if (rst)
                busy_q <= '0;
            else if (take)
                busy_q <= BNK_W'(BANK_CYCLES - 1);
            else if (busy_q != '0)
                busy_q <= busy_q - 1'b1;
        end

        assign bank_free[g] = (busy_q == '0);
    end

    AST_BUS_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        issue |-> cmd_free); // R9

    AST_BANK_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        issue |-> bank_free[issue_bank]); // R10

endmodule

// File: rtl/mrr_walker.sv
module mrr_walker
    import mrr_pkg::*;
#(
    parameter int ROWS          = 32768,
    parameter int BANKS         = 8,
    parameter int PERIOD_CYCLES = 64000000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     advance,
    output logic                     walking,
    output logic [$clog2(ROWS)-1:0]  cur_row,
    output logic [$clog2(BANKS)-1:0] cur_bank,
    output logic [1:0]               epoch
);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int BANK_W = $clog2(BANKS);
    localparam int IDX_W  = ROW_W + BANK_W;
    localparam int TMR_W  = $clog2(PERIOD_CYCLES);

    logic [IDX_W-1:0] idx_q;
    logic [TMR_W-1:0] tmr_q;
    logic             walking_q;
    logic [1:0]       epoch_q;
    logic             wrap, last;

    assign wrap = (tmr_q == TMR_W'(PERIOD_CYCLES - 1));
    assign last = (idx_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q     <= '0;
            idx_q     <= '0;
            walking_q <= 1'b1;
            epoch_q   <= 2'd0;
        end else begin
            tmr_q <= wrap ? '0 : tmr_q + 1'b1;
            if (wrap) begin
                idx_q     <= '0;
                walking_q <= 1'b1;
                epoch_q   <= epoch_q + 2'd1;
            end else if (advance && walking_q) begin
                if (last)
                    walking_q <= 1'b0;
                else
                    idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign walking  = walking_q;
    assign cur_row  = idx_q[IDX_W-1:BANK_W];
    assign cur_bank = idx_q[BANK_W-1:0];
    assign epoch    = epoch_q;

    AST_WALK_FITS: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (!walking_q || (advance && last))); // R2

    AST_EPOCH_STEP: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (epoch_q == 2'($past(epoch_q) + 2'd1))); // R8

endmodule

// File: rtl/multirate_refresh_sched.sv
module multirate_refresh_sched
    import mrr_pkg::*;
#(
    parameter int BANKS         = 8,
    parameter int ROWS          = 32768,
    parameter int FILTER_BITS   = 1024,
    parameter int PERIOD_CYCLES = 64000000,
    parameter int CMD_CYCLES    = 5,
    parameter int BANK_CYCLES   = 40
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   cfg_insert,
    input  logic                                   cfg_wipe,
    input  logic                                   cfg_fast_bin,
    input  logic [$clog2(ROWS)+$clog2(BANKS)-1:0]  cfg_key,
    output logic                                   ref_valid,
    output logic [$clog2(BANKS)-1:0]               ref_bank,
    output logic [$clog2(ROWS)-1:0]                ref_row,
    output logic [1:0]                             ref_class
);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int BANK_W = $clog2(BANKS);
    localparam int KEY_W  = ROW_W + BANK_W;
    localparam int GAP_W  = $clog2(CMD_CYCLES + 1);

    logic              walking, advance, issue, slot_free;
    logic [ROW_W-1:0]  cur_row;
    logic [BANK_W-1:0] cur_bank;
    logic [KEY_W-1:0]  cur_key;
    logic [1:0]        epoch;
    logic [1:0]        hit_vec;      // [0] fast bin, [1] medium bin
    logic              cmd_free;
    logic [BANKS-1:0]  bank_free;
    verdict_t          verdict;

    mrr_walker #(
        .ROWS(ROWS), .BANKS(BANKS), .PERIOD_CYCLES(PERIOD_CYCLES)
    ) u_walker (
        .clk(clk), .rst(rst), .advance(advance), .walking(walking),
        .cur_row(cur_row), .cur_bank(cur_bank), .epoch(epoch)
    );

    assign cur_key = {cur_row, cur_bank};

    for (genvar f = 0; f < 2; f++) begin : g_filter
        logic sel;
        assign sel = (cfg_fast_bin == (f == 0));
        mrr_bloom #(
            .KEY_W(KEY_W), .FILTER_BITS(FILTER_BITS)
        ) u_bloom (
            .clk(clk), .rst(rst),
            .wipe(cfg_wipe && sel), .insert(cfg_insert && sel),
            .ins_key(cfg_key), .probe_key(cur_key), .hit(hit_vec[f])
        );
    end

    mrr_occupancy #(
        .BANKS(BANKS), .CMD_CYCLES(CMD_CYCLES), .BANK_CYCLES(BANK_CYCLES)
    ) u_occ (
        .clk(clk), .rst(rst), .issue(issue), .issue_bank(cur_bank),
        .cmd_free(cmd_free), .bank_free(bank_free)
    );

    always_comb begin
        verdict   = judge(hit_vec[0], hit_vec[1], epoch, cur_row[1:0]);
        slot_free = cmd_free && bank_free[cur_bank];
        issue     = walking && verdict.due && slot_free;
        advance   = walking && (!verdict.due || slot_free);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_valid <= 1'b0;
            ref_bank  <= '0;
            ref_row   <= '0;
            ref_class <= RC_NONE;
        end else begin
            ref_valid <= issue;
            if (issue) begin
                ref_bank  <= cur_bank;
                ref_row   <= cur_row;
                ref_class <= verdict.cls;
            end
        end
    end

    // Cycles since the last command, saturating at the bus hold time
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst)
            gap_q <= GAP_W'(CMD_CYCLES);
        else if (ref_valid)
            gap_q <= GAP_W'(1);
        else if (gap_q < GAP_W'(CMD_CYCLES))
            gap_q <= gap_q + 1'b1;
    end

    AST_CMD_GAP: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> (gap_q >= GAP_W'(CMD_CYCLES))); // R9

    AST_CLASS_SET: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> (ref_class != RC_NONE)); // R5

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (walking && verdict.due && !slot_free) |=> $stable(cur_key)); // R11

endmodule

// File: tb/multirate_refresh_sched_test.sv
module multirate_refresh_sched_test;
    localparam int BANKS = 2;
    localparam int ROWS  = 8;
    localparam int FB    = 8;
    localparam int PER   = 300;
    localparam int CMDC  = 2;
    localparam int BNKC  = 5;
    localparam int KEYS  = ROWS * BANKS;
    localparam int NPER  = 14;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_insert = 1'b0, cfg_wipe = 1'b0, cfg_fast_bin = 1'b0;
    logic [3:0] cfg_key = '0;
    logic       ref_valid;
    logic [0:0] ref_bank;
    logic [2:0] ref_row;
    logic [1:0] ref_class;

    always #10 clk = ~clk;   // 50 MHz

    multirate_refresh_sched #(
        .BANKS(BANKS), .ROWS(ROWS), .FILTER_BITS(FB),
        .PERIOD_CYCLES(PER), .CMD_CYCLES(CMDC), .BANK_CYCLES(BNKC)
    ) uut (
        .clk(clk), .rst(rst), .cfg_insert(cfg_insert), .cfg_wipe(cfg_wipe),
        .cfg_fast_bin(cfg_fast_bin), .cfg_key(cfg_key), .ref_valid(ref_valid),
        .ref_bank(ref_bank), .ref_row(ref_row), .ref_class(ref_class)
    );

    int total = 0, bad = 0;
    int pc = 0;
    bit fbits[FB];
    bit mbits[FB];
    int got_cnt[KEYS];
    int got_cls[KEYS];
    int last_ref = -100;
    int last_bank_ref[BANKS];
    int last_key = -1;
    int cur_per = 0;

    always @(posedge clk) begin
        if (rst) pc <= 0;
        else     pc <= pc + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit probe(input bit fast, input int key);
        int a, b;
        a = key % FB;
        b = (5 * key + 3) % FB;
        if (fast) return fbits[a] && fbits[b];
        return mbits[a] && mbits[b];
    endfunction

    // Command monitor
    always @(negedge clk) begin
        if (!rst && ref_valid) begin
            int key, per;
            key = int'(ref_row) * BANKS + int'(ref_bank);
            per = (pc - 1) / PER;
            check(per == cur_per, "R2 period of command", per, cur_per);
            check(key > last_key, "R2 ascending index", key, last_key + 1);
            check(pc - last_ref >= CMDC, "R9 bus spacing", pc - last_ref, CMDC);
            check(pc - last_bank_ref[ref_bank] >= BNKC, "R10 bank spacing",
                  pc - last_bank_ref[ref_bank], BNKC);
            last_ref = pc;
            last_bank_ref[ref_bank] = pc;
            last_key = key;
            got_cnt[key]++;
            got_cls[key] = int'(ref_class);
        end
    end

    task automatic sync_to(input int t);
        while (pc < t) @(negedge clk);
    endtask

    task automatic cfg_pulse(input bit ins, input bit wipe, input bit fast, input int key);
        cfg_insert   = ins;
        cfg_wipe     = wipe;
        cfg_fast_bin = fast;
        cfg_key      = 4'(key);
        @(negedge clk);
        cfg_insert = 1'b0;
        cfg_wipe   = 1'b0;
        if (wipe) begin
            for (int i = 0; i < FB; i++) begin
                if (fast) fbits[i] = 1'b0;
                else      mbits[i] = 1'b0;
            end
        end else if (ins) begin
            if (fast) begin
                fbits[key % FB] = 1'b1;
                fbits[(5 * key + 3) % FB] = 1'b1;
            end else begin
                mbits[key % FB] = 1'b1;
                mbits[(5 * key + 3) % FB] = 1'b1;
            end
        end
    endtask

    task automatic verify_period(input int k);
        int e, due_total, got_total;
        e = k % 4;
        due_total = 0;
        got_total = 0;
        for (int key = 0; key < KEYS; key++) begin
            int row, cls;
            bit fh, mh, due;
            string tag;
            row = key / BANKS;
            fh = probe(1'b1, key);
            mh = probe(1'b0, key);
            if (fh) begin
                due = 1'b1; cls = 1;
                tag = mh ? "R7 both bins, fast wins" : "R5 fast bin";
            end else if (mh) begin
                due = ((e % 2) == (row % 2)); cls = 2; tag = "R6 medium bin";
            end else begin
                due = (e == (row % 4)); cls = 3; tag = "R8 default rate";
            end
            check(got_cnt[key] == int'(due), tag, got_cnt[key], int'(due));
            if (due && got_cnt[key] == 1)
                check(got_cls[key] == cls, tag, got_cls[key], cls);
            due_total += int'(due);
            got_total += got_cnt[key];
        end
        if (k == 4) begin
            // key 11 shares both hash bits with key 3: false positive
            check(got_cnt[11] == 1, "R3 shared-bit hit", got_cnt[11], 1);
            check(got_cnt[3] == 1, "R12 insert applies next period", got_cnt[3], 1);
        end
        if (k == 10)
            check(got_cnt[6] == 1 && got_cls[6] == 1, "R4 wipe spares fast bin",
                  got_cls[6], 1);
        if (k >= 12)
            check(got_total == KEYS, "R11 all due rows issued under stalls",
                  got_total, KEYS);
        else
            check(got_total == due_total, "R2 count per period", got_total, due_total);
    endtask

    initial begin
        for (int b = 0; b < BANKS; b++) last_bank_ref[b] = -100;
        for (int i = 0; i < KEYS; i++) begin got_cnt[i] = 0; got_cls[i] = 0; end
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(ref_valid == 1'b0, "R1 idle during reset", int'(ref_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(ref_valid == 1'b1 && ref_row == 3'd0 && ref_bank == 1'b0,
              "R1 first command one cycle after reset", int'(ref_valid), 1);
        for (int k = 0; k < NPER; k++) begin
            sync_to(k * PER + 200);
            verify_period(k);
            for (int i = 0; i < KEYS; i++) begin got_cnt[i] = 0; got_cls[i] = 0; end
            last_key = -1;
            cur_per = k + 1;
            sync_to(k * PER + 250);
            if (k == 3) begin
                cfg_pulse(1'b1, 1'b0, 1'b1, 3);
                cfg_pulse(1'b1, 1'b0, 1'b0, 6);
                cfg_pulse(1'b1, 1'b0, 1'b0, 9);
            end else if (k == 7) begin
                cfg_pulse(1'b1, 1'b0, 1'b1, 6);
            end else if (k == 9) begin
                cfg_pulse(1'b1, 1'b1, 1'b0, 12);   // R4: wipe beats insert
            end else if (k == 11) begin
                for (int key = 0; key < KEYS; key++) cfg_pulse(1'b1, 1'b0, 1'b1, key);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", pc, NPER * PER);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule